// File: doc/BRIEF.md
# Self-Identification Sequence Parser

After a bus reset, every PHY on a serial bus broadcasts one or more 32-bit self-identification quadlets. This block receives them one at a time on a valid/ready stream. Each quadlet comes with the number of quadlets still left in the receive buffer, counting the one being presented. The block groups the quadlets into one sequence per node. It checks the chaining and numbering rules that tie a node's quadlets together. When a sequence closes cleanly, it reports the node's fields and a decoded vector of per-port states.

A malformed quadlet raises a one-cycle protocol-error pulse. The block then discards the partial sequence and treats the next quadlet it receives as the start of a new sequence. A quadlet offered with a remaining count of zero produces an end-of-data pulse instead. It produces no error and no sequence output.

All outputs are registered. Each result appears in the cycle after the edge that accepts the quadlet which caused it. The sequence outputs hold their values until the next completed sequence.

Top module: `selfid_parser`

## Requirements
- R1: While reset is asserted, `in_ready`, `seq_done`, `proto_err` and `end_of_data` are 0. `in_ready` rises after the first clock edge with reset released and then stays 1.
- R2: Bits 31:30 hold the packet tag, and a self-ID quadlet carries tag 2. In the first quadlet, the fields sit as follows: physical ID in bits 29:24, link-active in bit 22, gap count in bits 21:16, speed code in bits 15:14, contender in bit 11, power class in bits 10:8 and initiated-reset in bit 1. When a sequence completes, these fields from its first quadlet appear on the outputs with `seq_done` = 1.
- R3: Ports 0, 1 and 2 are taken from bits 7:6, 5:4 and 3:2 of the first quadlet. Each port state is a 2-bit code: 0 none, 1 not connected, 2 to parent, 3 to child. Port p occupies `seq_ports[2p+1:2p]`.
- R4: Extended quadlet k (k = 1, 2, 3) carries ports 8k-5 to 8k+2, in that order, at bits 17:16 down to 3:2. Ports whose quadlet lies beyond the sequence report 0, so a sequence of n quadlets describes 8n-5 ports.
- R5: Bit 0 of a quadlet set to 1 means another quadlet of the same sequence follows. `seq_done` pulses only in the cycle after a quadlet with bit 0 clear is accepted, and `seq_count` then gives the sequence length, from 1 to 4.
- R6: A quadlet after the first with bit 23 clear is a protocol error.
- R7: In the quadlets after the first, bits 22:20 must equal 0, 1 and 2 in order. Any other value is a protocol error.
- R8: A fourth quadlet with bit 0 set is a protocol error.
- R9: A quadlet with bit 0 set that is accepted when the remaining count is 1 is a protocol error.
- R10: A quadlet whose tag is not 2 is a protocol error.
- R11: A quadlet accepted with a remaining count of 0 gives `end_of_data` for one cycle. It gives no `seq_done` and no `proto_err`, and it drops any partial sequence.
- R12: After a protocol error, the next accepted quadlet is treated as the first quadlet of a new sequence.
- R13: `seq_done`, `proto_err` and `end_of_data` are single-cycle pulses, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Quadlet offered |
| in_ready | output | 1 | Block accepts a quadlet |
| in_quadlet | input | 32 | Self-ID quadlet |
| in_remain | input | REM_W (16) | Quadlets left in the buffer, including this one |
| seq_done | output | 1 | Sequence completed, outputs valid |
| seq_phy_id | output | 6 | Physical ID |
| seq_count | output | CNT_W (3) | Number of quadlets in the sequence |
| seq_link_active | output | 1 | Link-active flag |
| seq_gap_count | output | 6 | Gap count |
| seq_speed | output | 2 | Speed code |
| seq_contender | output | 1 | Contender flag |
| seq_power | output | 3 | Power class |
| seq_init_reset | output | 1 | Initiated-reset flag |
| seq_ports | output | 2*PORTS (54) | Port states, 2 bits per port |
| proto_err | output | 1 | Protocol-error pulse |
| end_of_data | output | 1 | Empty-buffer pulse |

## Verification
The assertions check several rules on every cycle. The three pulses are mutually exclusive. Ready stays up once raised. A wrong tag, or a continuation flag set at the last buffered quadlet, is always followed by an error. An empty buffer is always followed by end-of-data. Every done follows a quadlet with the continuation flag clear and carries a count from 1 to 4, and a one-quadlet sequence never shows ports above port 2. Only the bench scenarios can show the decoded field values, the placement of ports across extended quadlets, the sequence-number and extended-bit errors, and the resynchronisation after an error. The bench compares these against a quadlet-queue model on every clock.

// File: rtl/selfid_pkg.sv
package selfid_pkg;

  localparam logic [1:0] TAG_SELFID = 2'd2;

  typedef struct packed {
    logic [5:0] phy_id;
    logic       link_active;
    logic [5:0] gap_count;
    logic [1:0] speed;
    logic       contender;
    logic [2:0] power;
    logic       init_reset;
  } node_info_t;

  // Field extraction from the first quadlet of a sequence
  function automatic node_info_t decode_base(logic [31:0] q);
    node_info_t n;
    n.phy_id      = q[29:24];
    n.link_active = q[22];
    n.gap_count   = q[21:16];
    n.speed       = q[15:14];
    n.contender   = q[11];
    n.power       = q[10:8];
    n.init_reset  = q[1];
    return n;
  endfunction

endpackage

// File: rtl/selfid_port_slot.sv
// Places the 2-bit port codes carried by one quadlet into the port vector.
// slot_bits holds quadlet bits 17:2.
module selfid_port_slot #(
  parameter int MAX_QUADS = 4,
  localparam int PORTS = 8 * MAX_QUADS - 5,
  localparam int QIW   = $clog2(MAX_QUADS)
) (
  input  logic [15:0]        slot_bits,
  input  logic [QIW-1:0]     slot_idx,
  output logic [2*PORTS-1:0] slot_data,
  output logic [2*PORTS-1:0] slot_mask
);

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    localparam int QI = (p + 5) / 8;
    localparam int SH = 16 - ((p + 5) % 8) * 2;
    logic hit;
    assign hit = (slot_idx == QIW'(QI));
    assign slot_data[2*p +: 2] = hit ? slot_bits[SH-2 +: 2] : 2'b00;
    assign slot_mask[2*p +: 2] = {2{hit}};
  end

endmodule

// File: rtl/selfid_chain_check.sv
// Judges one accepted quadlet against the chaining and numbering rules.
module selfid_chain_check #(
  parameter int REM_W     = 16,
  parameter int MAX_QUADS = 4,
  localparam int QIW      = $clog2(MAX_QUADS)
) (
  input  logic [1:0]       chk_tag,
  input  logic             chk_ext,
  input  logic [2:0]       chk_seqno,
  input  logic             chk_more,
  input  logic [QIW-1:0]   chk_idx,
  input  logic [REM_W-1:0] chk_remain,
  output logic             chk_bad
);
  import selfid_pkg::*;

  logic tag_bad;
  logic ext_bad;
  logic num_bad;
  logic over_bad;
  logic is_first;
  logic [2:0] want_seq;

  always_comb begin
    is_first = (chk_idx == '0);
    want_seq = 3'(chk_idx - 1'b1);
    tag_bad  = (chk_tag != TAG_SELFID);
    ext_bad  = !is_first && !chk_ext;
    num_bad  = !is_first && (chk_seqno != want_seq);
    over_bad = chk_more &&
               ((chk_remain == REM_W'(1)) || (chk_idx == QIW'(MAX_QUADS - 1)));
    chk_bad  = tag_bad || ext_bad || num_bad || over_bad;
  end

endmodule

// File: rtl/selfid_parser.sv
module selfid_parser #(
  parameter int REM_W     = 16,
  parameter int MAX_QUADS = 4,
  localparam int PORTS    = 8 * MAX_QUADS - 5,
  localparam int QIW      = $clog2(MAX_QUADS),
  localparam int CNT_W    = $clog2(MAX_QUADS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [31:0]        in_quadlet,
  input  logic [REM_W-1:0]   in_remain,
  output logic               seq_done,
  output logic [5:0]         seq_phy_id,
  output logic [CNT_W-1:0]   seq_count,
  output logic               seq_link_active,
  output logic [5:0]         seq_gap_count,
  output logic [1:0]         seq_speed,
  output logic               seq_contender,
  output logic [2:0]         seq_power,
  output logic               seq_init_reset,
  output logic [2*PORTS-1:0] seq_ports,
  output logic               proto_err,
  output logic               end_of_data
);
  import selfid_pkg::*;

  // State registers
  logic               ready_q;
  logic [QIW-1:0]     idx_q,   idx_d;
  node_info_t         info_q,  info_d;
  logic [2*PORTS-1:0] acc_q,   acc_d;
  logic               acc_en;
  // Output registers
  node_info_t         oinfo_q, oinfo_d;
  logic [2*PORTS-1:0] oport_q, oport_d;
  logic [CNT_W-1:0]   ocnt_q,  ocnt_d;
  logic               out_en;
  logic               done_q,  done_d;
  logic               err_q,   err_d;
  logic               eod_q,   eod_d;

  // Decode helpers
  logic               accept;
  logic               is_empty;
  logic               take;
  logic               bad;
  logic               more;
  node_info_t         cur_info;
  logic [2*PORTS-1:0] slot_data;
  logic [2*PORTS-1:0] slot_mask;
  logic [2*PORTS-1:0] merged;

  assign accept   = in_valid && ready_q;
  assign is_empty = (in_remain == '0);
  assign take     = accept && !is_empty;
  assign more     = in_quadlet[0];
  assign cur_info = decode_base(in_quadlet);

  selfid_port_slot #(
    .MAX_QUADS (MAX_QUADS)
  ) u_slot (
    .slot_bits (in_quadlet[17:2]),
    .slot_idx  (idx_q),
    .slot_data (slot_data),
    .slot_mask (slot_mask)
  );

  selfid_chain_check #(
    .REM_W     (REM_W),
    .MAX_QUADS (MAX_QUADS)
  ) u_check (
    .chk_tag    (in_quadlet[31:30]),
    .chk_ext    (in_quadlet[23]),
    .chk_seqno  (in_quadlet[22:20]),
    .chk_more   (more),
    .chk_idx    (idx_q),
    .chk_remain (in_remain),
    .chk_bad    (bad)
  );

  // Next-state logic
  always_comb begin
    idx_d   = idx_q;
    info_d  = info_q;
    acc_d   = acc_q;
    acc_en  = 1'b0;
    oinfo_d = oinfo_q;
    oport_d = oport_q;
    ocnt_d  = ocnt_q;
    out_en  = 1'b0;
    done_d  = 1'b0;
    err_d   = 1'b0;
    eod_d   = 1'b0;

    if (idx_q == '0) begin
      merged = slot_data;
    end else begin
      merged = (acc_q & ~slot_mask) | slot_data;
    end

    if (accept && is_empty) begin
      eod_d = 1'b1;
      idx_d = '0;
    end else if (take) begin
      if (bad) begin
        err_d = 1'b1;
        idx_d = '0;
      end else if (more) begin
        acc_en = 1'b1;
        acc_d  = merged;
        idx_d  = idx_q + 1'b1;
        if (idx_q == '0) begin
          info_d = cur_info;
        end
      end else begin
        out_en  = 1'b1;
        done_d  = 1'b1;
        idx_d   = '0;
        oport_d = merged;
        ocnt_d  = CNT_W'(idx_q) + 1'b1;
        oinfo_d = (idx_q == '0) ? cur_info : info_q;
      end
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      idx_q   <= '0;
      info_q  <= '0;
      acc_q   <= '0;
      oinfo_q <= '0;
      oport_q <= '0;
      ocnt_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      eod_q   <= 1'b0;
    end else begin
      ready_q <= 1'b1;
      idx_q   <= idx_d;
      done_q  <= done_d;
      err_q   <= err_d;
      eod_q   <= eod_d;
      if (acc_en) begin
        info_q <= info_d;
        acc_q  <= acc_d;
      end
      if (out_en) begin
        oinfo_q <= oinfo_d;
        oport_q <= oport_d;
        ocnt_q  <= ocnt_d;
      end
    end
  end

  assign in_ready        = ready_q;
  assign seq_done        = done_q;
  assign proto_err       = err_q;
  assign end_of_data     = eod_q;
  assign seq_phy_id      = oinfo_q.phy_id;
  assign seq_count       = ocnt_q;
  assign seq_link_active = oinfo_q.link_active;
  assign seq_gap_count   = oinfo_q.gap_count;
  assign seq_speed       = oinfo_q.speed;
  assign seq_contender   = oinfo_q.contender;
  assign seq_power       = oinfo_q.power;
  assign seq_init_reset  = oinfo_q.init_reset;
  assign seq_ports       = oport_q;

endmodule

// File: rtl/selfid_parser_chk.sv
module selfid_parser_chk #(
  parameter int REM_W     = 16,
  parameter int MAX_QUADS = 4,
  localparam int PORTS    = 8 * MAX_QUADS - 5,
  localparam int CNT_W    = $clog2(MAX_QUADS + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic [31:0]        in_quadlet,
  input logic [REM_W-1:0]   in_remain,
  input logic               seq_done,
  input logic [CNT_W-1:0]   seq_count,
  input logic [2*PORTS-1:0] seq_ports,
  input logic               proto_err,
  input logic               end_of_data
);

  logic acc;
  assign acc = in_valid && in_ready;

  AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({seq_done, proto_err, end_of_data})); // R13

  AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> in_ready); // R1

  AST_EOD_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_remain == '0) |=> end_of_data); // R11

  AST_TAG_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_remain != '0 && in_quadlet[31:30] != 2'd2) |=> proto_err); // R10

  AST_MORE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_remain == REM_W'(1) && in_quadlet[0]) |=> proto_err); // R9

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> $past(acc && !in_quadlet[0])); // R5

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> (seq_count >= CNT_W'(1) && seq_count <= CNT_W'(MAX_QUADS))); // R5

  AST_SHORT_PORTS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_done && seq_count == CNT_W'(1)) |-> (seq_ports[2*PORTS-1:6] == '0)); // R4

endmodule

bind selfid_parser selfid_parser_chk #(
  .REM_W     (REM_W),
  .MAX_QUADS (MAX_QUADS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_quadlet  (in_quadlet),
  .in_remain   (in_remain),
  .seq_done    (seq_done),
  .seq_count   (seq_count),
  .seq_ports   (seq_ports),
  .proto_err   (proto_err),
  .end_of_data (end_of_data)
);

// File: tb/test_selfid_parser.sv
module test_selfid_parser;
  localparam int CLK_PERIOD = 10;
  localparam int NPORT = 27;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_quadlet;
  logic [15:0] in_remain;
  logic        seq_done;
  logic [5:0]  seq_phy_id;
  logic [2:0]  seq_count;
  logic        seq_link_active;
  logic [5:0]  seq_gap_count;
  logic [1:0]  seq_speed;
  logic        seq_contender;
  logic [2:0]  seq_power;
  logic        seq_init_reset;
  logic [53:0] seq_ports;
  logic        proto_err;
  logic        end_of_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  selfid_parser i_selfid_parser (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_quadlet(in_quadlet), .in_remain(in_remain), .seq_done(seq_done),
    .seq_phy_id(seq_phy_id), .seq_count(seq_count),
    .seq_link_active(seq_link_active), .seq_gap_count(seq_gap_count),
    .seq_speed(seq_speed), .seq_contender(seq_contender),
    .seq_power(seq_power), .seq_init_reset(seq_init_reset),
    .seq_ports(seq_ports), .proto_err(proto_err), .end_of_data(end_of_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model state: quadlets of the open sequence
  logic [31:0] mq[$];

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_first(logic [5:0] phy, logic link,
      logic [5:0] gap, logic [1:0] spd, logic cont, logic [2:0] pwr,
      logic [5:0] p012, logic ir, logic more);
    return {2'b10, phy, 1'b0, link, gap, spd, 2'b00, cont, pwr, p012, ir, more};
  endfunction

  function automatic logic [31:0] mk_ext(logic [5:0] phy, logic [2:0] sq,
      logic [15:0] p8, logic more);
    return {2'b10, phy, 1'b1, sq, 2'b00, p8, 1'b0, more};
  endfunction

  // One clock: drive, model, compare on the cycle after the edge
  task automatic step(bit v, logic [31:0] d, int rem, string req);
    bit e_done = 0, e_err = 0, e_eod = 0;
    logic [31:0] f = '0;
    logic [53:0] ep = '0;
    int n = 0;
    @(negedge clk);
    in_valid = v; in_quadlet = d; in_remain = 16'(rem);
    if (v) begin
      if (rem == 0) begin
        e_eod = 1; mq.delete();
      end else begin
        int idx = mq.size();
        bit bad = (d[31:30] != 2'd2);
        if (idx > 0 && (!d[23] || int'(d[22:20]) != idx - 1)) bad = 1;
        if (d[0] && (rem == 1 || idx == 3)) bad = 1;
        if (bad) begin
          e_err = 1; mq.delete();
        end else begin
          mq.push_back(d);
          if (!d[0]) begin
            e_done = 1;
            n = mq.size();
            f = mq[0];
            for (int p = 0; p < NPORT; p++) begin
              int qi = (p + 5) / 8;
              int sh = 16 - ((p + 5) % 8) * 2;
              if (qi < n) ep[2*p +: 2] = mq[qi][sh +: 2];
            end
            mq.delete();
          end
        end
      end
    end
    @(posedge clk);
    #1;
    chk(req, "seq_done", seq_done, e_done);
    chk(req, "proto_err", proto_err, e_err);
    chk(req, "end_of_data", end_of_data, e_eod);
    if (e_done) begin
      chk(req, "phy_id", seq_phy_id, f[29:24]);
      chk(req, "count", seq_count, n);
      chk(req, "link", seq_link_active, f[22]);
      chk(req, "gap", seq_gap_count, f[21:16]);
      chk(req, "speed", seq_speed, f[15:14]);
      chk(req, "contender", seq_contender, f[11]);
      chk(req, "power", seq_power, f[10:8]);
      chk(req, "init_reset", seq_init_reset, f[1]);
      chk(req, "ports", seq_ports, ep);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL R13 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_quadlet = '0; in_remain = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "ready in reset", in_ready, 0);
    chk("R1", "done in reset", seq_done, 0);
    chk("R1", "err in reset", proto_err, 0);
    chk("R1", "eod in reset", end_of_data, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1", "ready after reset", in_ready, 1);

    // R2 R3: single quadlet sequence
    step(1, mk_first(6'd5, 1, 6'h3f, 2'd2, 1, 3'd5, 6'b11_10_01, 1, 0), 10, "R2");
    step(1, mk_first(6'd42, 0, 6'h0a, 2'd1, 0, 3'd2, 6'b01_00_11, 0, 0), 9, "R3");
    step(0, '0, 0, "R13");
    // R4 R5: two quadlets
    step(1, mk_first(6'd1, 1, 6'h10, 2'd3, 0, 3'd7, 6'b10_10_10, 0, 1), 8, "R5");
    step(1, mk_ext(6'd1, 3'd0, 16'b11_10_01_00_01_10_11_10, 0), 7, "R4");
    // four quadlets
    step(1, mk_first(6'd7, 0, 6'h01, 2'd0, 1, 3'd1, 6'b01_01_01, 1, 1), 6, "R5");
    step(1, mk_ext(6'd7, 3'd0, 16'hA5C3, 1), 5, "R4");
    step(1, mk_ext(6'd7, 3'd1, 16'h3C96, 1), 4, "R4");
    step(1, mk_ext(6'd7, 3'd2, 16'hF00F, 0), 3, "R5");
    // R8: more set on the fourth quadlet, then R12 resync
    step(1, mk_first(6'd2, 0, 6'h02, 2'd0, 0, 3'd0, 6'b11_11_11, 0, 1), 20, "R8");
    step(1, mk_ext(6'd2, 3'd0, 16'h1234, 1), 19, "R8");
    step(1, mk_ext(6'd2, 3'd1, 16'h5678, 1), 18, "R8");
    step(1, mk_ext(6'd2, 3'd2, 16'h9abc, 1), 17, "R8");
    step(1, mk_first(6'd3, 1, 6'h05, 2'd1, 1, 3'd4, 6'b00_01_10, 1, 0), 16, "R12");
    // R6: extended bit missing
    step(1, mk_first(6'd4, 0, 6'h06, 2'd2, 0, 3'd3, 6'b10_01_00, 0, 1), 15, "R6");
    step(1, mk_ext(6'd4, 3'd0, 16'hffff, 0) & ~32'h0080_0000, 14, "R6");
    step(1, mk_first(6'd9, 1, 6'h07, 2'd3, 1, 3'd6, 6'b11_00_11, 0, 0), 13, "R12");
    // R7: wrong sequence number
    step(1, mk_first(6'd10, 0, 6'h08, 2'd0, 0, 3'd0, 6'b01_10_11, 0, 1), 12, "R7");
    step(1, mk_ext(6'd10, 3'd1, 16'h0f0f, 0), 11, "R7");
    step(1, mk_first(6'd11, 0, 6'h09, 2'd0, 0, 3'd0, 6'b01_10_11, 0, 1), 10, "R7");
    step(1, mk_ext(6'd11, 3'd0, 16'h0f0f, 1), 9, "R7");
    step(1, mk_ext(6'd11, 3'd0, 16'hf0f0, 0), 8, "R7");
    // R10: bad tag, first and extended position
    step(1, mk_first(6'd12, 1, 6'h0b, 2'd1, 0, 3'd1, 6'b10_11_01, 0, 0) & ~32'h8000_0000, 7, "R10");
    step(1, mk_first(6'd13, 1, 6'h0c, 2'd1, 0, 3'd1, 6'b10_11_01, 0, 1), 6, "R10");
    step(1, mk_ext(6'd13, 3'd0, 16'h5555, 0) | 32'hc000_0000, 5, "R10");
    // R9: more flag on the last buffered quadlet
    step(1, mk_first(6'd14, 0, 6'h0d, 2'd2, 1, 3'd2, 6'b01_01_10, 1, 1), 1, "R9");
    step(1, mk_first(6'd15, 0, 6'h0e, 2'd2, 1, 3'd2, 6'b01_01_10, 1, 1), 2, "R9");
    step(1, mk_ext(6'd15, 3'd0, 16'haaaa, 1), 1, "R9");
    // R11: empty buffer, idle and mid-sequence
    step(1, mk_first(6'd16, 0, 6'h0f, 2'd0, 0, 3'd0, 6'b11_11_11, 0, 0), 0, "R11");
    step(1, mk_first(6'd17, 0, 6'h10, 2'd0, 0, 3'd0, 6'b11_10_01, 0, 1), 5, "R11");
    step(1, mk_ext(6'd17, 3'd0, 16'h1111, 0), 0, "R11");
    step(1, mk_first(6'd18, 1, 6'h11, 2'd3, 0, 3'd7, 6'b01_11_10, 1, 0), 4, "R11");
    // R13: back-to-back completions and idle cycles
    step(1, mk_first(6'd19, 1, 6'h12, 2'd1, 1, 3'd5, 6'b10_01_11, 0, 0), 3, "R13");
    step(1, mk_first(6'd20, 0, 6'h13, 2'd2, 0, 3'd6, 6'b11_01_10, 1, 0), 2, "R13");
    step(0, '0, 0, "R13");
    step(0, '0, 0, "R13");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule